// File: doc/BRIEF.md
# Data Watchpoint Range Comparator

This block watches a stream of memory accesses for a debugger. It holds a small table of data watchpoints. Each one has a start address, a byte length and two enables, one for reads and one for writes. Every access carries an address, a size in bytes and a direction. The access is compared against all stored watchpoints in parallel. The test asks whether the two inclusive byte ranges overlap at all. It has no alignment or power-of-two limits, and a range that ends on the last byte of the address space is handled correctly.

When an access matches, the unit keeps a hit record: the watchpoint index, the direction of the access and the access address. It also raises a one-cycle debug-event pulse. The record stays frozen until an acknowledge input clears it. A configuration port adds and removes watchpoints. It answers each command with a one-cycle done or error pulse.

Top module: `wp_unit`

## Requirements
- R1: An enabled watchpoint matches an access when the access's byte range [addr, addr+size-1] and the watchpoint's range [base, base+len-1] share at least one byte. Partial overlap from either side counts, and so does full containment.
- R2: A watchpoint's end is inclusive (base+len-1). A watchpoint ending at address 2^ADDR_W-1 matches accesses to that last byte. An access whose end runs past the top of the address space is compared as if it had no upper bound.
- R3: An add command is rejected when len is 0 or when base+len-1 exceeds 2^ADDR_W-1. A rejected add gives cfg_err_o and stores nothing.
- R4: An add command accepts any base and any non-zero length with no alignment rule. It places the entry in the lowest-numbered free slot and gives cfg_done_o. When all slots are in use it gives cfg_err_o instead. cfg_done_o and cfg_err_o are registered one-cycle pulses and are never high together.
- R5: A watchpoint matches a read access (acc_write_i=0) only if its read enable is set, and a write access (acc_write_i=1) only if its write enable is set.
- R6: On the clock edge that samples a matching access while no hit is held, the unit stores the hit. hit_idx_o takes the slot index. Exactly one of hit_read_o and hit_write_o is set, following the access direction. hit_addr_o takes the access address. hit_active_o and a one-cycle hit_o pulse are raised.
- R7: While a hit is held, later matching accesses change no part of the record and raise no hit_o pulse.
- R8: A remove command (cfg_del_i=1) frees the lowest slot whose base, length, read enable and write enable all equal the command's values, and gives cfg_done_o. If no slot matches exactly, it gives cfg_err_o and every entry is kept.
- R9: When several watchpoints match one access, the lowest slot index is recorded.
- R10: ack_i clears the record, so that hit_active_o, hit_read_o, hit_write_o, hit_idx_o and hit_addr_o all become zero. If a matching access arrives in the same cycle as ack_i, that access is recorded as a new hit. Reset clears the record and empties all slots.
- R11: An access with acc_size_i equal to 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration command strobe |
| cfg_del_i | input | 1 | 0: add watchpoint, 1: remove watchpoint |
| cfg_base_i | input | ADDR_W | Watchpoint start address |
| cfg_len_i | input | ADDR_W | Watchpoint length in bytes |
| cfg_rd_en_i | input | 1 | Match reads |
| cfg_wr_en_i | input | 1 | Match writes |
| cfg_done_o | output | 1 | Command accepted (pulse) |
| cfg_err_o | output | 1 | Command rejected (pulse) |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Access start address |
| acc_size_i | input | SIZE_W | Access size in bytes |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| ack_i | input | 1 | Clear the hit record |
| hit_o | output | 1 | Debug-event pulse for a newly recorded hit |
| hit_active_o | output | 1 | A hit is held |
| hit_idx_o | output | IDX_W | Slot that hit |
| hit_read_o | output | 1 | Held hit came from a read |
| hit_write_o | output | 1 | Held hit came from a write |
| hit_addr_o | output | ADDR_W | Address of the access that hit |

## Verification
Directed accesses approach each watchpoint from below, from above, from inside and from all around it. These cases separate a true overlap test from a start-address or aligned-mask comparison. Watchpoints and accesses placed at the very top of the address space show whether the inclusive end is computed without wrapping to zero. Accesses with the wrong direction, and accesses that hit two watchpoints at once, test the enable gating and the priority rule. A long pseudo-random run then mixes accesses near every boundary with acknowledges, adds and removes. It compares every output with a behavioural model on each clock.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    CFG_ADD = 1'b0,
    CFG_DEL = 1'b1
  } cfg_op_e;
endpackage

// File: rtl/wp_slot.sv
module wp_slot #(
  parameter int ADDR_W = 32,
  localparam int EXT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_len_i,
  input  logic [ADDR_W-1:0] cfg_last_i,
  input  logic              cfg_rd_en_i,
  input  logic              cfg_wr_en_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [EXT_W-1:0]  acc_last_i,
  input  logic              acc_write_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] len_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              match_o
);
  logic [ADDR_W-1:0] last_q;
  logic              overlap, dir_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      base_o  <= '0;
      len_o   <= '0;
      last_q  <= '0;
      rd_en_o <= 1'b0;
      wr_en_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      base_o  <= cfg_base_i;
      len_o   <= cfg_len_i;
      last_q  <= cfg_last_i;
      rd_en_o <= cfg_rd_en_i;
      wr_en_o <= cfg_wr_en_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  // inclusive ends; access end carries one extra bit so it cannot wrap
  assign overlap = !(({1'b0, acc_addr_i} > {1'b0, last_q}) ||
                     ({1'b0, base_o} > acc_last_i));
  assign dir_ok  = acc_write_i ? wr_en_o : rd_en_o;
  assign match_o = valid_o && acc_valid_i && overlap && dir_ok;

  logic [EXT_W-1:0] stored_end;
  assign stored_end = {1'b0, base_o} + {1'b0, len_o} - EXT_W'(1);

  assert_slot_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0) && !stored_end[ADDR_W]);

  assert_load_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && clear_i));
endmodule

// File: rtl/wp_cfg_ctrl.sv
module wp_cfg_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_WP   = 4,
  localparam int EXT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  cfg_op_e           cfg_op_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_len_i,
  input  logic              cfg_rd_en_i,
  input  logic              cfg_wr_en_i,
  input  logic [N_WP-1:0]   slot_valid_i,
  input  logic [ADDR_W-1:0] slot_base_i [N_WP],
  input  logic [ADDR_W-1:0] slot_len_i  [N_WP],
  input  logic [N_WP-1:0]   slot_rd_en_i,
  input  logic [N_WP-1:0]   slot_wr_en_i,
  output logic [ADDR_W-1:0] cfg_last_o,
  output logic [N_WP-1:0]   load_o,
  output logic [N_WP-1:0]   clear_o,
  output logic              done_o,
  output logic              err_o
);
  logic [EXT_W-1:0] end_ext;
  logic             range_ok;
  logic [N_WP-1:0]  free_first, same_first;
  logic             any_free, any_same;

  assign end_ext    = {1'b0, cfg_base_i} + {1'b0, cfg_len_i} - EXT_W'(1);
  assign range_ok   = (cfg_len_i != '0) && !end_ext[ADDR_W];
  assign cfg_last_o = end_ext[ADDR_W-1:0];

  always_comb begin
    free_first = '0;
    same_first = '0;
    any_free   = 1'b0;
    any_same   = 1'b0;
    for (int i = 0; i < N_WP; i++) begin
      if (!slot_valid_i[i] && !any_free) begin
        free_first[i] = 1'b1;
        any_free      = 1'b1;
      end
      if (slot_valid_i[i] && !any_same &&
          slot_base_i[i] == cfg_base_i && slot_len_i[i] == cfg_len_i &&
          slot_rd_en_i[i] == cfg_rd_en_i && slot_wr_en_i[i] == cfg_wr_en_i) begin
        same_first[i] = 1'b1;
        any_same      = 1'b1;
      end
    end
  end

  logic add_ok, del_ok;
  assign add_ok  = cfg_valid_i && cfg_op_i == CFG_ADD && range_ok && any_free;
  assign del_ok  = cfg_valid_i && cfg_op_i == CFG_DEL && any_same;
  assign load_o  = add_ok ? free_first : '0;
  assign clear_o = del_ok ? same_first : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= add_ok || del_ok;
      err_o  <= cfg_valid_i && !(add_ok || del_ok);
    end
  end

  assert_status_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));

  assert_bad_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_op_i == CFG_ADD && cfg_len_i == '0 |=> err_o);

  assert_single_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o) && $onehot0(clear_o));
endmodule

// File: rtl/wp_hit_rec.sv
module wp_hit_rec #(
  parameter int ADDR_W = 32,
  parameter int N_WP   = 4,
  localparam int IDX_W = (N_WP > 1) ? $clog2(N_WP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WP-1:0]   match_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              ack_i,
  output logic              hit_o,
  output logic              active_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [IDX_W-1:0] sel;
  logic             any, take;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = N_WP - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  assign take = any && (!active_o || ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      active_o <= 1'b0;
      idx_o    <= '0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
      addr_o   <= '0;
    end else begin
      hit_o <= take;
      if (take) begin
        active_o <= 1'b1;
        idx_o    <= sel;
        rd_o     <= !acc_write_i;
        wr_o     <= acc_write_i;
        addr_o   <= acc_addr_i;
      end else if (ack_i) begin
        active_o <= 1'b0;
        idx_o    <= '0;
        rd_o     <= 1'b0;
        wr_o     <= 1'b0;
        addr_o   <= '0;
      end
    end
  end

  assert_hit_record_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> active_o && (rd_o != wr_o));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !ack_i |=> !hit_o && $stable(idx_o) && $stable(addr_o) && $stable(rd_o));

  assert_ack_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && (match_i == '0) |=> !active_o && !rd_o && !wr_o);

  assert_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && match_i[0] |=> idx_o == '0);
endmodule

// File: rtl/wp_unit.sv
module wp_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int N_WP   = 4,
  localparam int IDX_W = (N_WP > 1) ? $clog2(N_WP) : 1,
  localparam int EXT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic              cfg_del_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_len_i,
  input  logic              cfg_rd_en_i,
  input  logic              cfg_wr_en_i,
  output logic              cfg_done_o,
  output logic              cfg_err_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  input  logic              acc_write_i,
  input  logic              ack_i,
  output logic              hit_o,
  output logic              hit_active_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic              hit_read_o,
  output logic              hit_write_o,
  output logic [ADDR_W-1:0] hit_addr_o
);
  logic [N_WP-1:0]   slot_valid, slot_rd, slot_wr, slot_match, load, clear;
  logic [ADDR_W-1:0] slot_base [N_WP];
  logic [ADDR_W-1:0] slot_len  [N_WP];
  logic [ADDR_W-1:0] cfg_last;
  logic [EXT_W-1:0]  acc_last;
  logic              acc_live;
  cfg_op_e           cfg_op;

  assign cfg_op   = cfg_del_i ? CFG_DEL : CFG_ADD;
  assign acc_live = acc_valid_i && (acc_size_i != '0);
  assign acc_last = {1'b0, acc_addr_i} + EXT_W'(acc_size_i) - EXT_W'(1);

  wp_cfg_ctrl #(.ADDR_W(ADDR_W), .N_WP(N_WP)) i_cfg (
    .clk_i, .rst_ni,
    .cfg_valid_i, .cfg_op_i(cfg_op), .cfg_base_i, .cfg_len_i,
    .cfg_rd_en_i, .cfg_wr_en_i,
    .slot_valid_i(slot_valid), .slot_base_i(slot_base), .slot_len_i(slot_len),
    .slot_rd_en_i(slot_rd), .slot_wr_en_i(slot_wr),
    .cfg_last_o(cfg_last), .load_o(load), .clear_o(clear),
    .done_o(cfg_done_o), .err_o(cfg_err_o)
  );

  for (genvar g = 0; g < N_WP; g++) begin : g_slot
    wp_slot #(.ADDR_W(ADDR_W)) i_slot (
      .clk_i, .rst_ni,
      .load_i(load[g]), .clear_i(clear[g]),
      .cfg_base_i, .cfg_len_i, .cfg_last_i(cfg_last),
      .cfg_rd_en_i, .cfg_wr_en_i,
      .acc_valid_i(acc_live), .acc_addr_i, .acc_last_i(acc_last), .acc_write_i,
      .valid_o(slot_valid[g]), .base_o(slot_base[g]), .len_o(slot_len[g]),
      .rd_en_o(slot_rd[g]), .wr_en_o(slot_wr[g]), .match_o(slot_match[g])
    );
  end

  wp_hit_rec #(.ADDR_W(ADDR_W), .N_WP(N_WP)) i_rec (
    .clk_i, .rst_ni,
    .match_i(slot_match), .acc_addr_i, .acc_write_i, .ack_i,
    .hit_o, .active_o(hit_active_o), .idx_o(hit_idx_o),
    .rd_o(hit_read_o), .wr_o(hit_write_o), .addr_o(hit_addr_o)
  );

  assert_zero_size_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_size_i == '0 && !hit_active_o |=> !hit_o);

  assert_dir_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_write_o == $past(acc_write_i));
endmodule

// File: tb/test_wp_unit.sv
module test_wp_unit;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int NW = 4;
  localparam longint TOP = 64'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_valid = 0, cfg_del = 0, cfg_rd = 0, cfg_wr = 0;
  logic [AW-1:0] cfg_base = '0, cfg_len = '0;
  logic acc_valid = 0, acc_write = 0, ack = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [SW-1:0] acc_size = '0;
  logic cfg_done, cfg_err, hit, hit_active, hit_read, hit_write;
  logic [1:0] hit_idx;
  logic [AW-1:0] hit_addr;

  wp_unit i_wp_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_del_i(cfg_del), .cfg_base_i(cfg_base),
    .cfg_len_i(cfg_len), .cfg_rd_en_i(cfg_rd), .cfg_wr_en_i(cfg_wr),
    .cfg_done_o(cfg_done), .cfg_err_o(cfg_err),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_size_i(acc_size),
    .acc_write_i(acc_write), .ack_i(ack),
    .hit_o(hit), .hit_active_o(hit_active), .hit_idx_o(hit_idx),
    .hit_read_o(hit_read), .hit_write_o(hit_write), .hit_addr_o(hit_addr)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  bit m_v[NW], m_rd[NW], m_wr[NW];
  longint m_base[NW], m_len[NW];
  bit m_act, m_r, m_w, m_hit, m_done, m_err;
  int m_idx;
  longint m_addr;

  task automatic model_edge();
    longint a, ae;
    int found;
    m_hit = 0; m_done = 0; m_err = 0;
    if (ack) begin
      m_act = 0; m_r = 0; m_w = 0; m_idx = 0; m_addr = 0;
    end
    if (acc_valid && acc_size != 0) begin
      a = longint'(acc_addr); ae = a + longint'(acc_size) - 1;
      found = -1;
      for (int i = NW - 1; i >= 0; i--)
        if (m_v[i] && !(a > m_base[i] + m_len[i] - 1 || m_base[i] > ae) &&
            (acc_write ? m_wr[i] : m_rd[i])) found = i;
      if (found >= 0 && !m_act) begin
        m_act = 1; m_hit = 1; m_idx = found; m_addr = a;
        m_r = !acc_write; m_w = acc_write;
      end
    end
    if (cfg_valid) begin
      found = -1;
      if (!cfg_del) begin
        if (cfg_len != 0 && longint'(cfg_base) + longint'(cfg_len) - 1 <= TOP)
          for (int i = NW - 1; i >= 0; i--) if (!m_v[i]) found = i;
        if (found >= 0) begin
          m_v[found] = 1; m_base[found] = longint'(cfg_base);
          m_len[found] = longint'(cfg_len); m_rd[found] = cfg_rd; m_wr[found] = cfg_wr;
        end
      end else begin
        for (int i = NW - 1; i >= 0; i--)
          if (m_v[i] && m_base[i] == longint'(cfg_base) && m_len[i] == longint'(cfg_len) &&
              m_rd[i] == cfg_rd && m_wr[i] == cfg_wr) found = i;
        if (found >= 0) m_v[found] = 0;
      end
      if (found >= 0) m_done = 1; else m_err = 1;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (hit !== m_hit || hit_active !== m_act || int'(hit_idx) !== m_idx ||
        hit_read !== m_r || hit_write !== m_w || longint'(hit_addr) !== m_addr ||
        cfg_done !== m_done || cfg_err !== m_err) begin
      errors++;
      $display("FAIL %s: got hit=%0b act=%0b idx=%0d r=%0b w=%0b addr=%h done=%0b err=%0b, expected hit=%0b act=%0b idx=%0d r=%0b w=%0b addr=%h done=%0b err=%0b",
        tag, hit, hit_active, hit_idx, hit_read, hit_write, hit_addr, cfg_done, cfg_err,
        m_hit, m_act, m_idx, m_r, m_w, m_addr[31:0], m_done, m_err);
    end
  endtask

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    cfg_valid = 0; acc_valid = 0; ack = 0;
  endtask

  task automatic add(bit del, logic [AW-1:0] b, logic [AW-1:0] l, bit r, bit w, string tag);
    cfg_valid = 1; cfg_del = del; cfg_base = b; cfg_len = l; cfg_rd = r; cfg_wr = w;
    step(tag);
  endtask

  task automatic acc(logic [AW-1:0] a, int sz, bit w, bit k, string tag);
    acc_valid = 1; acc_addr = a; acc_size = SW'(sz); acc_write = w; ack = k;
    step(tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [AW-1:0] picks [8];
    for (int i = 0; i < NW; i++) begin m_v[i] = 0; m_base[i] = 0; m_len[i] = 0; m_rd[i] = 0; m_wr[i] = 0; end
    m_act = 0; m_r = 0; m_w = 0; m_idx = 0; m_addr = 0; m_hit = 0; m_done = 0; m_err = 0;
    repeat (3) @(negedge clk);
    compare("R10 reset state");
    rst_n = 1;
    @(negedge clk);
    compare("R10 after reset");

    add(0, 32'h100, 32'd3, 1, 0, "R4 unaligned odd length");
    add(0, 32'hFFFF_FFF0, 32'd16, 1, 1, "R2 range at top");
    add(0, 32'h400, 32'd0, 1, 1, "R3 zero length");
    add(0, 32'hFFFF_FFF8, 32'd9, 1, 1, "R3 end wraps");
    add(0, 32'h200, 32'd1, 0, 1, "R4 single byte");
    add(0, 32'h300, 32'd8, 1, 1, "R4 fourth slot");
    add(0, 32'h500, 32'd4, 1, 1, "R4 table full");

    acc(32'h101, 1, 1, 0, "R5 write to read-only entry");
    acc(32'h0FE, 2, 0, 0, "R1 just below range");
    acc(32'h103, 4, 0, 0, "R1 just above range");
    acc(32'h101, 0, 0, 0, "R11 zero size");
    acc(32'h0FE, 3, 0, 0, "R1 R6 partial overlap from below");
    acc(32'h200, 1, 1, 0, "R7 later hit held");
    acc(32'h000, 1, 0, 1, "R10 ack");
    acc(32'h0F8, 15, 0, 0, "R1 access covers range");
    acc(32'h000, 1, 0, 1, "R10 ack");
    acc(32'hFFFF_FFFF, 1, 1, 0, "R2 last byte");
    acc(32'h200, 1, 1, 1, "R10 ack with new hit");
    acc(32'h000, 1, 0, 1, "R10 ack");
    acc(32'hFFFF_FFFC, 8, 0, 0, "R2 access running past top");
    acc(32'h000, 1, 0, 1, "R10 ack");

    add(1, 32'h300, 32'd8, 1, 0, "R8 flag mismatch kept");
    acc(32'h307, 1, 0, 0, "R8 entry still present");
    acc(32'h000, 1, 0, 1, "R10 ack");
    add(1, 32'h300, 32'd8, 1, 1, "R8 exact remove");
    acc(32'h300, 8, 0, 0, "R8 removed entry silent");
    add(1, 32'h300, 32'd8, 1, 1, "R8 remove absent");
    add(0, 32'h1FE, 32'd4, 1, 1, "R4 refill free slot");
    acc(32'h200, 1, 1, 0, "R9 two matches lowest wins");
    acc(32'h000, 1, 0, 1, "R10 ack");

    picks[0] = 32'h0FE; picks[1] = 32'h100; picks[2] = 32'h1FC; picks[3] = 32'h200;
    picks[4] = 32'h2FF; picks[5] = 32'hFFFF_FFF0; picks[6] = 32'hFFFF_FFF9; picks[7] = 32'h500;
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc_valid = lfsr[0] | lfsr[1];
      acc_addr  = picks[lfsr[4:2]] + AW'(lfsr[7:5]);
      acc_size  = SW'(lfsr[11:8]);
      acc_write = lfsr[12];
      ack       = (lfsr[15:13] == 3'd0);
      if (lfsr[15:12] == 4'hF) begin
        cfg_valid = 1; cfg_del = lfsr[3];
        cfg_base  = picks[lfsr[6:4]] + AW'(lfsr[1:0]);
        cfg_len   = AW'(lfsr[9:7]);
        cfg_rd    = lfsr[10]; cfg_wr = lfsr[11];
      end
      step("R1 R5 R6 R7 R9 mixed traffic");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule